// File: doc/BRIEF.md
# Snoop-Result Response Agent

This block is the response-side controller that a memory agent uses on a pipelined, split-transaction processor bus. Every request phase hands it a set of attributes: whether the requester allows deferral, whether the request belongs to a locked sequence and whether it opens that sequence, and a 3-bit request type. The attributes wait in an in-order queue. When the snoop slot of the oldest waiting transaction arrives, the block samples two snoop results once: a "stall" result, which stands for a defer request, and a "dirty" result, which reports a modified-line hit. From these results and the stored attributes it chooses a single response code.

The block then sequences the response phase. A dirty hit starts the implicit-writeback sequence. The block raises the writeback-ready strobe one clock after it samples the snoop. It issues the response two clocks after that strobe. Four data beats follow, and the first of them falls in the response clock. Clean completions of read requests carry four data beats that start with the response. All other responses take a single clock. An illegal combination of attributes and snoop result is reported as an error response code.

The sequencer is a five-state machine. ST_IDLE waits for a snoop on a non-empty queue and leaves to one of three states. It goes to ST_TRDY on a dirty result, to ST_DATA for a clean read completion, and to ST_RESP otherwise. ST_TRDY always moves to ST_GAP. ST_GAP always moves to ST_DATA. ST_RESP returns to ST_IDLE after one clock. ST_DATA returns to ST_IDLE after its last beat. The queue entry is retired on the clock that leaves ST_RESP or ST_DATA.

Top module: `snoop_resp_agent`

## Requirements
- R1: After reset, wb_ready, rsp_valid, data_busy, mem_capture and iq_full are all low.
- R2: Requests are held in an in-order queue of 4 entries and are answered in the order they were accepted. iq_full is high exactly while 4 entries are held.
- R3: A snoop is accepted only while the sequencer is in ST_IDLE and the queue is not empty. A snp_valid pulse while the queue is empty produces no output activity.
- R4: If the stall result is low and the dirty result is low, the response is normal (code 3'b000). For read types 3'b010 and 3'b011, four data beats (data_beat 0 to 3) accompany it, with beat 0 in the response clock. Other types get a one-clock response with no data.
- R5: A dirty result gives implicit writeback (code 3'b001). wb_ready is high for one clock, one clock after the snoop is sampled. The response comes two clocks after wb_ready, with data_busy high from that clock for four beats numbered 0 to 3.
- R6: If the stall result is high, the dirty result is low and defer-enable is set, the response is deferred (code 3'b011).
- R7: If the stall result is high, the dirty result is low and defer-enable is clear, the response is retry (code 3'b010) for any request that may be retried.
- R8: An explicit writeback (type 3'b101) or a locked request that is not the first of its sequence, with the stall result high and the dirty result low, gives the error code 3'b111.
- R9: A request with defer-enable set that is locked, is a deferred reply (type 3'b000) or is an explicit writeback (type 3'b101) gives the error code 3'b111 whatever its snoop results are.
- R10: A deferred reply (type 3'b000) with the dirty result high gets implicit writeback with mem_capture held low. Without the dirty result it gets no-data (code 3'b100). For every other type, mem_capture is high on each implicit-writeback beat.
- R11: rsp_valid is high for exactly one clock per transaction. After the response clock, or after the last data beat, the block is idle until the next snoop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request phase strobe; pushes the attributes into the queue |
| req_defer_en | input | 1 | Requester allows a deferred response |
| req_lock | input | 1 | Request belongs to a locked sequence |
| req_lock_first | input | 1 | Request is the first of its locked sequence |
| req_type | input | 3 | Request type code |
| iq_full | output | 1 | In-order queue holds its maximum number of entries |
| snp_valid | input | 1 | Snoop slot of the oldest waiting transaction |
| snp_stall | input | 1 | Snoop result: defer requested |
| snp_dirty | input | 1 | Snoop result: modified-line hit |
| wb_ready | output | 1 | Memory agent ready to accept writeback data |
| rsp_valid | output | 1 | Response code valid, one clock |
| rsp_code | output | 3 | Response code (000 normal, 001 implicit writeback, 010 retry, 011 deferred, 100 no-data, 111 error) |
| data_busy | output | 1 | Data phase beat in progress |
| data_beat | output | 2 | Index of the current data beat |
| mem_capture | output | 1 | Memory should store this writeback beat |

## Verification
The assertions check the fixed timing relations on every cycle. They cover the two-clock gap from wb_ready to the writeback response, the one-clock width of rsp_valid, the increasing beat numbers, the rule that beat 0 comes with the response, and mem_capture appearing only inside a data phase. Only the bench's scenarios can show which code each combination of attributes and snoop results produces. The same is true of whether a deferred reply suppresses the memory write, whether responses follow request order through a full queue, and whether an unexpected snoop on an empty queue is ignored.

// File: rtl/sra_pkg.sv
package sra_pkg;

    typedef enum logic [2:0] {
        RC_NORMAL = 3'b000,
        RC_IWB    = 3'b001,
        RC_RETRY  = 3'b010,
        RC_DEFER  = 3'b011,
        RC_NODATA = 3'b100,
        RC_ERROR  = 3'b111
    } rsp_code_e;

    typedef struct packed {
        logic       defer_en;
        logic       lock;
        logic       lock_first;
        logic [2:0] rtype;
    } req_attr_t;

    localparam logic [2:0] T_DREPLY = 3'b000;
    localparam logic [2:0] T_READ   = 3'b010;
    localparam logic [2:0] T_RDINV  = 3'b011;
    localparam logic [2:0] T_WBACK  = 3'b101;

endpackage

// File: rtl/sra_iq.sv
module sra_iq
    import sra_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      push,
    input  req_attr_t din,
    input  logic      pop,
    output req_attr_t dout,
    output logic      empty,
    output logic      full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = AW + 1;

    req_attr_t         slots [DEPTH];
    logic [AW-1:0]     wr_ptr, rd_ptr;
    logic [CW-1:0]     count;
    logic              do_push, do_pop;

    assign empty   = (count == '0);
    assign full    = (count == CW'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = slots[rd_ptr];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) begin
                wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            end
            if (do_pop) begin
                rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            end
            count <= count + CW'(do_push) - CW'(do_pop);
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) begin
            slots[wr_ptr] <= din;
        end
    end

endmodule

// File: rtl/sra_decode.sv
module sra_decode
    import sra_pkg::*;
(
    input  req_attr_t attr,
    input  logic      stall,
    input  logic      dirty,
    output rsp_code_e code,
    output logic      data_phase,
    output logic      mem_cap
);
    logic is_dreply, is_wback, is_read, late_lock, bad_enable;

    assign is_dreply  = (attr.rtype == T_DREPLY);
    assign is_wback   = (attr.rtype == T_WBACK);
    assign is_read    = (attr.rtype == T_READ) || (attr.rtype == T_RDINV);
    assign late_lock  = attr.lock && !attr.lock_first;
    assign bad_enable = attr.defer_en && (attr.lock || is_dreply || is_wback);

    always_comb begin
        if (bad_enable) begin
            code = RC_ERROR;
        end else if (dirty) begin
            code = RC_IWB;
        end else if (is_dreply) begin
            code = RC_NODATA;
        end else if (!stall) begin
            code = RC_NORMAL;
        end else if (is_wback || late_lock) begin
            code = RC_ERROR;
        end else if (attr.defer_en) begin
            code = RC_DEFER;
        end else begin
            code = RC_RETRY;
        end
    end

    assign data_phase = (code == RC_IWB) || ((code == RC_NORMAL) && is_read);
    assign mem_cap    = (code == RC_IWB) && !is_dreply;

endmodule

// File: rtl/sra_seq.sv
module sra_seq
    import sra_pkg::*;
#(
    parameter int BEATS = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        start,
    input  rsp_code_e                   code_in,
    input  logic                        data_in,
    input  logic                        memcap_in,
    output logic                        idle,
    output logic                        done,
    output logic                        wb_ready,
    output logic                        rsp_valid,
    output logic [2:0]                  rsp_code,
    output logic                        data_busy,
    output logic [$clog2(BEATS)-1:0]    data_beat,
    output logic                        mem_capture
);
    localparam int BW = $clog2(BEATS);
    localparam logic [BW-1:0] LAST = BW'(BEATS - 1);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_TRDY,
        ST_GAP,
        ST_RESP,
        ST_DATA
    } state_e;

    state_e          state, nxt;
    rsp_code_e       code_q;
    logic            memcap_q;
    logic [BW-1:0]   beat_q;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (start) begin
                    if (code_in == RC_IWB) nxt = ST_TRDY;
                    else if (data_in)      nxt = ST_DATA;
                    else                   nxt = ST_RESP;
                end
            end
            ST_TRDY: nxt = ST_GAP;
            ST_GAP:  nxt = ST_DATA;
            ST_RESP: nxt = ST_IDLE;
            ST_DATA: if (beat_q == LAST) nxt = ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            code_q   <= RC_NORMAL;
            memcap_q <= 1'b0;
            beat_q   <= '0;
        end else begin
            state <= nxt;
            if (state == ST_IDLE && start) begin
                code_q   <= code_in;
                memcap_q <= memcap_in;
            end
            beat_q <= (state == ST_DATA) ? beat_q + 1'b1 : '0;
        end
    end

    always_comb begin
        wb_ready    = (state == ST_TRDY);
        data_busy   = (state == ST_DATA);
        rsp_valid   = (state == ST_RESP) || (data_busy && beat_q == '0);
        rsp_code    = rsp_valid ? code_q : 3'b000;
        data_beat   = data_busy ? beat_q : '0;
        mem_capture = data_busy && memcap_q;
        done        = (state == ST_RESP) || (data_busy && beat_q == LAST);
        idle        = (state == ST_IDLE);
    end

endmodule

// File: rtl/snoop_resp_agent.sv
module snoop_resp_agent
    import sra_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int BEATS = 4,
    parameter int BW    = $clog2(BEATS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          req_defer_en,
    input  logic          req_lock,
    input  logic          req_lock_first,
    input  logic [2:0]    req_type,
    output logic          iq_full,
    input  logic          snp_valid,
    input  logic          snp_stall,
    input  logic          snp_dirty,
    output logic          wb_ready,
    output logic          rsp_valid,
    output logic [2:0]    rsp_code,
    output logic          data_busy,
    output logic [BW-1:0] data_beat,
    output logic          mem_capture
);
    req_attr_t in_attr, head;
    rsp_code_e dec_code;
    logic      iq_empty, seq_idle, seq_done, start, dec_data, dec_mem;

    assign in_attr = '{defer_en: req_defer_en, lock: req_lock,
                       lock_first: req_lock_first, rtype: req_type};
    assign start   = snp_valid && !iq_empty && seq_idle;

    sra_iq #(.DEPTH(DEPTH)) iq_i (
        .clk(clk), .rst_n(rst_n),
        .push(req_valid), .din(in_attr),
        .pop(seq_done), .dout(head),
        .empty(iq_empty), .full(iq_full)
    );

    sra_decode dec_i (
        .attr(head), .stall(snp_stall), .dirty(snp_dirty),
        .code(dec_code), .data_phase(dec_data), .mem_cap(dec_mem)
    );

    sra_seq #(.BEATS(BEATS)) seq_i (
        .clk(clk), .rst_n(rst_n),
        .start(start), .code_in(dec_code), .data_in(dec_data), .memcap_in(dec_mem),
        .idle(seq_idle), .done(seq_done),
        .wb_ready(wb_ready), .rsp_valid(rsp_valid), .rsp_code(rsp_code),
        .data_busy(data_busy), .data_beat(data_beat), .mem_capture(mem_capture)
    );

endmodule

// File: rtl/sra_checker.sv
module sra_checker #(
    parameter int BEATS = 4,
    parameter int BW    = $clog2(BEATS)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic          iq_full,
    input logic          wb_ready,
    input logic          rsp_valid,
    input logic [2:0]    rsp_code,
    input logic          data_busy,
    input logic [BW-1:0] data_beat,
    input logic          mem_capture
);
    localparam logic [BW-1:0] LAST = BW'(BEATS - 1);

    AST_NO_PUSH_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> !iq_full);                                                   // R2

    AST_TRDY_QUIET_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        wb_ready |=> (!rsp_valid && !data_busy && !wb_ready));                     // R5

    AST_IWB_TWO_AFTER_TRDY: assert property (@(posedge clk) disable iff (!rst_n)
        wb_ready |=> ##1 (rsp_valid && rsp_code == 3'b001 && data_busy));          // R5

    AST_FIRST_BEAT_WITH_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(data_busy) |-> (rsp_valid && data_beat == '0));                      // R4

    AST_BEAT_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (data_busy && data_beat != LAST) |=>
            (data_busy && data_beat == BW'($past(data_beat) + 1'b1)));             // R5

    AST_RSP_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);                                                 // R11

    AST_CAPTURE_IN_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        mem_capture |-> data_busy);                                                // R10

    AST_ERROR_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_code == 3'b111) |-> !data_busy);                         // R9

endmodule

bind snoop_resp_agent sra_checker #(.BEATS(BEATS)) chk_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .iq_full(iq_full),
    .wb_ready(wb_ready), .rsp_valid(rsp_valid), .rsp_code(rsp_code),
    .data_busy(data_busy), .data_beat(data_beat), .mem_capture(mem_capture)
);

// File: tb/snoop_resp_agent_tb_top.sv
module snoop_resp_agent_tb_top;

    typedef struct {
        bit       de;
        bit       lk;
        bit       lf;
        bit [2:0] t;
    } mreq_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0, req_defer_en = 1'b0, req_lock = 1'b0, req_lock_first = 1'b0;
    logic [2:0] req_type = 3'b000;
    logic       snp_valid = 1'b0, snp_stall = 1'b0, snp_dirty = 1'b0;
    logic       iq_full, wb_ready, rsp_valid, data_busy, mem_capture;
    logic [2:0] rsp_code;
    logic [1:0] data_beat;

    int    n_checks = 0;
    int    n_fail   = 0;
    bit    finished = 0;
    mreq_t mq[$];

    always #2 clk = ~clk;

    snoop_resp_agent dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_defer_en(req_defer_en), .req_lock(req_lock),
        .req_lock_first(req_lock_first), .req_type(req_type), .iq_full(iq_full),
        .snp_valid(snp_valid), .snp_stall(snp_stall), .snp_dirty(snp_dirty),
        .wb_ready(wb_ready), .rsp_valid(rsp_valid), .rsp_code(rsp_code),
        .data_busy(data_busy), .data_beat(data_beat), .mem_capture(mem_capture)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // expected code chosen from the requirement text
    function automatic int want_code(input mreq_t r, input bit st, input bit dt);
        bit forbidden = r.de && (r.lk || r.t == 3'b000 || r.t == 3'b101);
        if (forbidden) return 7;                                  // R9
        if (dt) return 1;                                         // R5
        if (r.t == 3'b000) return 4;                              // R10
        if (!st) return 0;                                        // R4
        if (r.t == 3'b101 || (r.lk && !r.lf)) return 7;           // R8
        return r.de ? 3 : 2;                                      // R6 / R7
    endfunction

    task automatic idle_check(input string tag);
        int act = {wb_ready, rsp_valid, data_busy, mem_capture};
        check(act == 0, tag, act, 0);
    endtask

    task automatic push_req(input bit de, input bit lk, input bit lf, input bit [2:0] t);
        mreq_t r;
        @(negedge clk);
        req_valid = 1'b1; req_defer_en = de; req_lock = lk; req_lock_first = lf; req_type = t;
        @(negedge clk);
        req_valid = 1'b0;
        r.de = de; r.lk = lk; r.lf = lf; r.t = t;
        mq.push_back(r);
        idle_check("R11 idle while queuing");
    endtask

    // drive one snoop slot and compare the outputs on each of the following clocks
    task automatic snoop(input bit st, input bit dt, input string tag);
        mreq_t h = mq.pop_front();
        int    c = want_code(h, st, dt);
        bit    rd = (h.t == 3'b010 || h.t == 3'b011);
        snp_valid = 1'b1; snp_stall = st; snp_dirty = dt;
        for (int k = 1; k <= 7; k++) begin
            bit e_tr = 0, e_rv = 0, e_db = 0, e_mc = 0;
            int e_bt = 0, act, exp;
            @(negedge clk);
            snp_valid = 1'b0; snp_stall = 1'b0; snp_dirty = 1'b0;
            if (c == 1) begin
                e_tr = (k == 1);
                e_rv = (k == 3);
                e_db = (k >= 3 && k <= 6);
                e_bt = k - 3;
                e_mc = e_db && (h.t != 3'b000);
            end else if (c == 0 && rd) begin
                e_rv = (k == 1);
                e_db = (k <= 4);
                e_bt = k - 1;
            end else begin
                e_rv = (k == 1);
            end
            act = {wb_ready, rsp_valid, data_busy, mem_capture};
            exp = {e_tr, e_rv, e_db, e_mc};
            check(act == exp, {tag, " strobes"}, act, exp);
            if (e_rv) check(rsp_code == 3'(c), {tag, " code"}, rsp_code, c);
            if (e_db) check(data_beat == 2'(e_bt), {tag, " beat"}, data_beat, e_bt);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        idle_check("R1 reset outputs");
        check(iq_full == 1'b0, "R1 iq_full after reset", iq_full, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R3: snoop with empty queue is ignored
        snp_valid = 1'b1; snp_dirty = 1'b1;
        @(negedge clk);
        snp_valid = 1'b0; snp_dirty = 1'b0;
        repeat (4) begin
            @(negedge clk);
            idle_check("R3 empty-queue snoop ignored");
        end

        push_req(0, 0, 0, 3'b010); snoop(0, 0, "R4 read normal with data");
        push_req(0, 0, 0, 3'b100); snoop(0, 0, "R4 write normal no data");
        push_req(1, 0, 0, 3'b011); snoop(0, 0, "R4 read-inv normal with data");
        push_req(0, 0, 0, 3'b011); snoop(1, 1, "R5 implicit writeback");
        push_req(1, 0, 0, 3'b010); snoop(1, 1, "R5 dirty beats stall");
        push_req(1, 0, 0, 3'b010); snoop(1, 0, "R6 deferred");
        push_req(0, 0, 0, 3'b010); snoop(1, 0, "R7 retry");
        push_req(0, 1, 1, 3'b100); snoop(1, 0, "R7 first locked retry");
        push_req(0, 0, 0, 3'b101); snoop(1, 0, "R8 writeback not retryable");
        push_req(0, 1, 0, 3'b010); snoop(1, 0, "R8 late locked not retryable");
        push_req(0, 0, 0, 3'b101); snoop(0, 0, "R8 writeback completes normally");
        push_req(1, 1, 1, 3'b010); snoop(0, 0, "R9 locked with defer-enable");
        push_req(1, 0, 0, 3'b101); snoop(0, 1, "R9 writeback with defer-enable");
        push_req(0, 0, 0, 3'b000); snoop(0, 1, "R10 deferred reply with data");
        push_req(0, 0, 0, 3'b000); snoop(1, 0, "R10 deferred reply no data");

        // R2: fill the queue, then answer in order
        push_req(0, 0, 0, 3'b010);
        push_req(1, 0, 0, 3'b011);
        push_req(0, 0, 0, 3'b000);
        push_req(0, 0, 0, 3'b100);
        check(iq_full == 1'b1, "R2 queue full at 4 entries", iq_full, 1);
        snoop(1, 0, "R2 order entry0");
        check(iq_full == 1'b0, "R2 queue not full after retire", iq_full, 0);
        snoop(1, 0, "R2 order entry1");
        snoop(0, 1, "R2 order entry2");
        snoop(0, 0, "R2 order entry3");
        repeat (3) begin
            @(negedge clk);
            idle_check("R11 idle after drain");
        end

        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=0x0 expected=0x1");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule